// File: doc/BRIEF.md
# Dual-Channel PWM Timer with Shadowed Compare Values

This block is an up-counting pulse-width timer with two compare channels, A and B. The counter moves one step on each clock cycle where the prescaler enable is high. It runs from zero up to a programmable top value and then returns to zero. Each channel compares the counter with an active compare value and drives a true output and a complementary output. Each of these outputs has its own enable. A 2-bit mode per channel selects how the outputs behave.

Software writes new compare values over a small register port. A written value goes into a shadow register and reaches the active comparator only on the enabled tick where the counter sits at top. A change of duty cycle therefore takes effect at a period boundary and cannot cut a pulse short. A read of a compare address returns the shadow register, so the value read back is always the value most recently written. The top register has no shadow: a write to it takes effect at once.

Top module: `pwm_dualbuf_timer`

## Requirements
- R1: The counter changes only on cycles where `tick` is high. On such a cycle it goes from the top value to 0, and otherwise it adds 1. It can be read at address 3.
- R2: A write to address 1 (channel A) or address 2 (channel B) updates only that channel's shadow register. The active compare value takes the shadow value only on a cycle where `tick` is high and the counter equals top.
- R3: Reading address 1 or address 2 returns that channel's shadow register, even before the value is latched. Address 0 reads the top register and address 3 reads the counter.
- R4: Suppose a compare write lands on the same cycle as a latch. The active register then takes the previous shadow value, and the new value stays pending until the next latch.
- R5: Mode 00 drives both of that channel's outputs low and both enables low.
- R6: In modes 01 and 10, with an active value strictly between 0 and top, the true output is high exactly while 1 ≤ counter < active. It goes low at the compare match and high again when the counter equals 1. Its enable is high.
- R7: In mode 01 the complementary output is enabled, and with an active value strictly between 0 and top it is high exactly while counter > active. It is set one tick after the match and cleared at 0. In modes 10 and 11 the complementary output is low and its enable is low.
- R8: In mode 11, with an active value strictly between 0 and top, the true output is high exactly while counter > active, and its enable is high.
- R9: When the active value is 0, the true output is held low in modes 01 and 10 and held high in mode 11. In that case the mode 01 complementary output is held high. When the active value equals top (and is not 0), these levels are all inverted.
- R10: A synchronous reset clears the counter and both shadow and active registers, and sets the top register to all ones.
- R11: A write to address 0 replaces the top value immediately. The next wrap happens when the counter equals the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Prescaler enable; counter steps when high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 top, 1 compare A, 2 compare B, 3 counter (read only) |
| wr_data | input | W | Write data |
| rd_data | output | W | Read data for `addr` |
| mode_a | input | 2 | Channel A output mode |
| mode_b | input | 2 | Channel B output mode |
| pwm_a | output | 1 | Channel A true output |
| pwm_a_n | output | 1 | Channel A complementary output |
| oe_a | output | 1 | Channel A true output enable |
| oe_a_n | output | 1 | Channel A complementary output enable |
| pwm_b | output | 1 | Channel B true output |
| pwm_b_n | output | 1 | Channel B complementary output |
| oe_b | output | 1 | Channel B true output enable |
| oe_b_n | output | 1 | Channel B complementary output enable |

## Verification
The bench builds the timer with `W = 4`, so the top register resets to 15. At that width every compare value from 0 to top can be swept for several top settings (15, 9 and 4) in all four modes within a few thousand cycles. That puts both constant-level cases, the single-count pulses next to them and every counter state within reach. Channel B is given the mirrored compare value and mode at the same time. Compare writes are issued alongside active ticks, so some land exactly on the latch cycle. Periods run with the enable high on every cycle and also high on every other cycle.

// File: rtl/pwm_dualbuf_timer.sv
module pwm_dualbuf_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [1:0]   mode_a,
  input  logic [1:0]   mode_b,
  output logic         pwm_a,
  output logic         pwm_a_n,
  output logic         oe_a,
  output logic         oe_a_n,
  output logic         pwm_b,
  output logic         pwm_b_n,
  output logic         oe_b,
  output logic         oe_b_n
);

  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt, top, hold_a, hold_b, act_a, act_b;
  logic         at_top, latch;

  assign at_top = (cnt == top);
  assign latch  = tick && at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= ZERO;
      top    <= ONES;
      hold_a <= ZERO;
      hold_b <= ZERO;
      act_a  <= ZERO;
      act_b  <= ZERO;
    end else begin
      if (tick) cnt <= at_top ? ZERO : cnt + ONE;
      if (latch) begin
        act_a <= hold_a;
        act_b <= hold_b;
      end
      if (wr_en) begin
        case (addr)
          2'd0:    top    <= wr_data;
          2'd1:    hold_a <= wr_data;
          2'd2:    hold_b <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rd_data = top;
      2'd1:    rd_data = hold_a;
      2'd2:    rd_data = hold_b;
      default: rd_data = cnt;
    endcase
  end

  // returns {oe, oe_n, p, p_n}
  function automatic logic [3:0] chan(input logic [1:0] m, input logic [W-1:0] c,
                                      input logic [W-1:0] a, input logic [W-1:0] t);
    logic up, dn, p, pn;
    up = (c != ZERO) && (c < a);
    dn = (c > a);
    p  = 1'b0;
    pn = 1'b0;
    if (m == 2'b11) begin
      if (a == ZERO)   p = 1'b1;
      else if (a == t) p = 1'b0;
      else             p = dn;
    end else begin
      if (a == ZERO) begin
        p = 1'b0; pn = 1'b1;
      end else if (a == t) begin
        p = 1'b1; pn = 1'b0;
      end else begin
        p = up; pn = dn;
      end
    end
    case (m)
      2'b00:   chan = 4'b0000;
      2'b01:   chan = {2'b11, p, pn};
      default: chan = {2'b10, p, 1'b0};
    endcase
  endfunction

  assign {oe_a, oe_a_n, pwm_a, pwm_a_n} = chan(mode_a, cnt, act_a, top);
  assign {oe_b, oe_b_n, pwm_b, pwm_b_n} = chan(mode_b, cnt, act_b, top);

  assert_cnt_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
  assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == top) |=> (cnt == ZERO));
  assert_act_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !latch |=> ($stable(act_a) && $stable(act_b)));
  assert_act_load_R4: assert property (@(posedge clk) disable iff (rst)
    latch |=> (act_a == $past(hold_a) && act_b == $past(hold_b)));
  assert_off_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_a == 2'b00) |-> (!oe_a && !oe_a_n && !pwm_a && !pwm_a_n));
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    !(pwm_a && pwm_a_n) && !(pwm_b && pwm_b_n));
  assert_match_low_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_a == 2'b01 && act_a != ZERO && act_a != top && cnt == act_a) |-> !pwm_a);

endmodule

// File: tb/pwm_dualbuf_timer_tb.sv
module pwm_dualbuf_timer_tb_top;
  localparam int W = 4;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0, mode_a = 2'd0, mode_b = 2'd0;
  logic [W-1:0] wr_data = '0, rd_data;
  logic pwm_a, pwm_a_n, oe_a, oe_a_n, pwm_b, pwm_b_n, oe_b, oe_b_n;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] m_cnt, m_top, m_ha, m_hb, m_aa, m_ab;

  always #(PERIOD/2) clk = ~clk;

  pwm_dualbuf_timer #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .mode_a(mode_a), .mode_b(mode_b),
    .pwm_a(pwm_a), .pwm_a_n(pwm_a_n), .oe_a(oe_a), .oe_a_n(oe_a_n),
    .pwm_b(pwm_b), .pwm_b_n(pwm_b_n), .oe_b(oe_b), .oe_b_n(oe_b_n));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // expected {oe, oe_n, p, p_n} from the requirements
  function automatic logic [3:0] expect_ch(input logic [1:0] m, input int c, input int a, input int t);
    logic p, pn;
    if (m == 2'b00) return 4'b0000;
    if (m == 2'b11) begin
      p = (a == 0) ? 1'b1 : (a == t) ? 1'b0 : (c > a);
      return {2'b10, p, 1'b0};
    end
    if (a == 0)      begin p = 1'b0; pn = 1'b1; end
    else if (a == t) begin p = 1'b1; pn = 1'b0; end
    else             begin p = (c >= 1 && c < a); pn = (c > a); end
    return (m == 2'b01) ? {2'b11, p, pn} : {2'b10, p, 1'b0};
  endfunction

  function automatic string tag_of(input logic [1:0] m, input int a, input int t, input bit comp);
    if (m == 2'b00) return "R5";
    if (a == 0 || a == t) return "R9";
    if (comp) return "R7";
    return (m == 2'b11) ? "R8" : "R6";
  endfunction

  task automatic check_all();
    logic [3:0] ea, eb;
    ea = expect_ch(mode_a, m_cnt, m_aa, m_top);
    eb = expect_ch(mode_b, m_cnt, m_ab, m_top);
    chk(tag_of(mode_a, m_aa, m_top, 0), {oe_a, oe_a_n, pwm_a}, ea[3:1]);
    chk(tag_of(mode_a, m_aa, m_top, 1), pwm_a_n, ea[0]);
    chk(tag_of(mode_b, m_ab, m_top, 0), {oe_b, oe_b_n, pwm_b}, eb[3:1]);
    chk(tag_of(mode_b, m_ab, m_top, 1), pwm_b_n, eb[0]);
    case (addr)
      2'd0: chk("R11 top read", rd_data, m_top);
      2'd1: chk("R3 read A", rd_data, m_ha);
      2'd2: chk("R3 read B", rd_data, m_hb);
      default: chk("R1 counter", rd_data, m_cnt);
    endcase
  endtask

  task automatic step(input logic t, input logic w, input logic [1:0] a, input logic [W-1:0] d);
    tick = t; wr_en = w; addr = a; wr_data = d;
    @(posedge clk);
    if (t) begin
      if (m_cnt == m_top) begin m_cnt = '0; m_aa = m_ha; m_ab = m_hb; end
      else m_cnt = m_cnt + 1'b1;
    end
    if (w) case (a)
      2'd0: m_top = d;
      2'd1: m_ha = d;
      2'd2: m_hb = d;
      default: ;
    endcase
    @(negedge clk);
    check_all();
  endtask

  initial begin
    m_cnt = '0; m_top = '1; m_ha = '0; m_hb = '0; m_aa = '0; m_ab = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    addr = 2'd0; #1 chk("R10 top reset", rd_data, 15);
    addr = 2'd1; #1 chk("R10 shadow A reset", rd_data, 0);
    addr = 2'd2; #1 chk("R10 shadow B reset", rd_data, 0);
    addr = 2'd3; #1 chk("R10 counter reset", rd_data, 0);
    @(negedge clk);
    // R1 idle: no tick, counter holds
    for (int i = 0; i < 3; i++) step(0, 0, 2'd3, '0);
    // R2/R3: write pending, readback before latch
    mode_a = 2'b01; mode_b = 2'b11;
    step(1, 1, 2'd1, 4'd6);
    step(0, 0, 2'd1, '0);
    chk("R2 active unchanged before top", pwm_a, 0);
    // R4: write exactly on latch tick
    while (m_cnt != m_top) step(1, 0, 2'd3, '0);
    step(1, 1, 2'd1, 4'd9);
    for (int i = 0; i < 20; i++) step(1, 0, 2'd1, '0);
    // R11: shrink top mid-count
    step(1, 1, 2'd0, 4'd12);
    for (int i = 0; i < 30; i++) step(1, 0, 2'd3, '0);
    // exhaustive sweep
    for (int ti = 0; ti < 3; ti++) begin
      int tv = (ti == 0) ? 15 : (ti == 1) ? 9 : 4;
      step(1, 1, 2'd0, W'(tv));
      for (int c = 0; c <= tv; c++) begin
        for (int m = 0; m < 4; m++) begin
          mode_a = 2'(m); mode_b = 2'(3 - m);
          step(1, 1, 2'd1, W'(c));
          step(1, 1, 2'd2, W'(tv - c));
          for (int i = 0; i < 3 * (tv + 1); i++) begin
            bit tk = (m[0] == 1'b0) || (i % 2 == 0);
            step(tk, 0, 2'(i % 4), '0);
          end
        end
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule